// File: doc/BRIEF.md
# ASK/PSK Half-Bit LF Modulator

This block turns logical bits held in an external buffer into a timed on/off or phase-flip pattern for a low-frequency carrier. Each logical bit arrives as a pair of half bits. The block presents the lower half bit, then the upper half bit, and holds each one for half a bit period. A half-bit timer counts a 1 µs tick input, and a two-bit rate code selects one of four durations. The block does not generate the carrier and does not model the analog driver. It only produces the carrier gate, the carrier phase-inversion control and a modulation-active flag.

A transmission begins when the command decoder pulses `start` while the buffer holds data. It continues as long as the buffer can supply the next pair at the exact end of each upper half bit. It ends in one of two ways:
- when the buffer is found empty at that point, or
- at once on a stop request or a fault.

The output gate depends on the mode. In on/off keying mode the gate follows the half-bit value. In phase mode the gate stays on for the whole transmission, and the phase control toggles each time the half-bit value changes from one half bit to the next.

Top module: `lf_halfbit_mod`

## Requirements
- R1: During and directly after reset, `mod_active`, `carrier_en`, `carrier_inv` and `buf_pop` are all 0.
- R2: When idle, `start` with `buf_valid` high (and no `stop`/`fault`) asserts `buf_pop` in that same cycle and raises `mod_active` in the next cycle. `start` while `buf_valid` is low is ignored and `mod_active` stays 0.
- R3: Each half bit lasts a number of tick pulses set by `cfg_rate` (bit 0 is the low rate bit): code 0 gives 512, code 1 gives 256, code 2 gives 160 and code 3 gives 128.
- R4: Of each popped pair, `buf_pair[0]` is presented first and `buf_pair[1]` second, each for a full half-bit duration.
- R5: With `cfg_psk`=0, `carrier_en` equals the current half bit while active, and `carrier_inv` is 0.
- R6: With `cfg_psk`=1, `carrier_en` is 1 for the whole transmission. `carrier_inv` is 0 on the first half bit and then toggles in exactly the cycles where the half-bit value differs from the previous half bit.
- R7: `mod_active` stays 1 for the whole transmission, including half bits of value 0. While it is 0, `carrier_en` and `carrier_inv` are 0.
- R8: When an upper half bit ends and `buf_valid` is high, the next pair is popped in that same cycle, so there is no idle cycle between logical bits.
- R9: When an upper half bit ends and `buf_valid` is low, `mod_active` falls in the next cycle.
- R10: `stop` or `fault` ends a transmission in the next cycle. In a cycle with `stop` or `fault` there is no pop, and `start` is ignored.
- R11: The half-bit timer advances only in cycles where `tick_us` is 1, so a transmission cannot end in a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| cfg_rate | input | 2 | Half-bit duration select |
| cfg_psk | input | 1 | 0: on/off keying, 1: phase keying |
| start | input | 1 | Data-write command accepted |
| stop | input | 1 | Stop request |
| fault | input | 1 | Fault shutdown request |
| buf_valid | input | 1 | Buffer holds at least one pair |
| buf_pair | input | 2 | Head pair: bit 0 lower half, bit 1 upper half |
| buf_pop | output | 1 | Remove head pair this cycle |
| mod_active | output | 1 | Transmission in progress |
| carrier_en | output | 1 | Carrier gate |
| carrier_inv | output | 1 | Carrier 180° phase inversion |

## Verification
The bench builds the block with its default duration table (512, 256, 160 and 128 ticks) and with phase keying enabled, so the exact durations are measured at every rate. The tick input is driven every cycle for most runs, which keeps even the 512-tick setting short. One run drives the tick every third cycle to show that the timer counts ticks and not clocks. Data such as the 0F6h pattern exposes the lower-first ordering, the gapless fetch of the next pair, and the phase toggling on each value change.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

   typedef logic [1:0] lfm_rate_t;
   typedef logic [1:0] lfm_pair_t;

   function automatic int lfm_max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/lfm_baud_timer.sv
module lfm_baud_timer
   import lfm_pkg::*;
#(
   parameter int HALF_R0 = 512,
   parameter int HALF_R1 = 256,
   parameter int HALF_R2 = 160,
   parameter int HALF_R3 = 128,
   parameter int CNT_W   = 10
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  logic      tick,
   input  lfm_rate_t rate,
   output logic      half_done
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;

   always_comb begin
      case (rate)
         2'd0:    last_val = CNT_W'(HALF_R0 - 1);
         2'd1:    last_val = CNT_W'(HALF_R1 - 1);
         2'd2:    last_val = CNT_W'(HALF_R2 - 1);
         default: last_val = CNT_W'(HALF_R3 - 1);
      endcase
   end

   assign half_done = run && tick && (cnt_q >= last_val);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
      end else if (half_done) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/lfm_sequencer.sv
module lfm_sequencer
   import lfm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      stop,
   input  logic      fault,
   input  logic      buf_valid,
   input  lfm_pair_t buf_pair,
   input  logic      half_done,
   output logic      pop,
   output logic      active,
   output logic      cur_bit,
   output logic      first_bit
);

   logic      active_q;
   logic      upper_q;
   lfm_pair_t pair_q;
   logic      first_q;
   logic      abort;
   logic      launch;
   logic      refill;

   assign abort  = stop || fault;
   assign launch = !abort && !active_q && start && buf_valid;
   assign refill = !abort && active_q && half_done && upper_q && buf_valid;
   assign pop    = launch || refill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         upper_q  <= 1'b0;
         pair_q   <= '0;
         first_q  <= 1'b0;
      end else if (abort) begin
         active_q <= 1'b0;
         upper_q  <= 1'b0;
      end else if (launch) begin
         active_q <= 1'b1;
         upper_q  <= 1'b0;
         pair_q   <= buf_pair;
         first_q  <= buf_pair[0];
      end else if (active_q && half_done) begin
         if (!upper_q) begin
            upper_q <= 1'b1;
         end else if (buf_valid) begin
            upper_q <= 1'b0;
            pair_q  <= buf_pair;
         end else begin
            active_q <= 1'b0;
            upper_q  <= 1'b0;
         end
      end
   end

   assign active    = active_q;
   assign cur_bit   = upper_q ? pair_q[1] : pair_q[0];
   assign first_bit = first_q;

endmodule

// File: rtl/lfm_keyer.sv
module lfm_keyer #(
   parameter bit ENABLE_PSK = 1'b1
) (
   input  logic active,
   input  logic psk,
   input  logic cur_bit,
   input  logic first_bit,
   output logic gate,
   output logic invert
);

   generate
      if (ENABLE_PSK) begin : g_psk
         assign gate   = active && (psk || cur_bit);
         assign invert = active && psk && (cur_bit ^ first_bit);
      end else begin : g_ask_only
         logic unused_psk;
         assign unused_psk = psk ^ first_bit;
         assign gate       = active && cur_bit;
         assign invert     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/lf_halfbit_mod.sv
module lf_halfbit_mod
   import lfm_pkg::*;
#(
   parameter int HALF_R0    = 512,
   parameter int HALF_R1    = 256,
   parameter int HALF_R2    = 160,
   parameter int HALF_R3    = 128,
   parameter bit ENABLE_PSK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_us,
   input  logic [1:0] cfg_rate,
   input  logic       cfg_psk,
   input  logic       start,
   input  logic       stop,
   input  logic       fault,
   input  logic       buf_valid,
   input  logic [1:0] buf_pair,
   output logic       buf_pop,
   output logic       mod_active,
   output logic       carrier_en,
   output logic       carrier_inv
);

   localparam int HALF_MAX = lfm_max4(HALF_R0, HALF_R1, HALF_R2, HALF_R3);
   localparam int CNT_W    = (HALF_MAX < 2) ? 1 : $clog2(HALF_MAX);

   generate
      if (HALF_R0 < 1 || HALF_R1 < 1 || HALF_R2 < 1 || HALF_R3 < 1) begin : g_bad_len
         $error("lf_halfbit_mod: every half-bit length must be at least one tick");
      end
   endgenerate

   logic half_done;
   logic active;
   logic cur_bit;
   logic first_bit;

   lfm_baud_timer #(
      .HALF_R0 (HALF_R0),
      .HALF_R1 (HALF_R1),
      .HALF_R2 (HALF_R2),
      .HALF_R3 (HALF_R3),
      .CNT_W   (CNT_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (active),
      .tick      (tick_us),
      .rate      (cfg_rate),
      .half_done (half_done)
   );

   lfm_sequencer u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .stop      (stop),
      .fault     (fault),
      .buf_valid (buf_valid),
      .buf_pair  (buf_pair),
      .half_done (half_done),
      .pop       (buf_pop),
      .active    (active),
      .cur_bit   (cur_bit),
      .first_bit (first_bit)
   );

   lfm_keyer #(
      .ENABLE_PSK (ENABLE_PSK)
   ) u_keyer (
      .active    (active),
      .psk       (cfg_psk),
      .cur_bit   (cur_bit),
      .first_bit (first_bit),
      .gate      (carrier_en),
      .invert    (carrier_inv)
   );

   assign mod_active = active;

endmodule

// File: rtl/lfm_checker.sv
module lfm_checker (
   input logic clk,
   input logic rst_n,
   input logic tick_us,
   input logic cfg_psk,
   input logic start,
   input logic stop,
   input logic fault,
   input logic buf_valid,
   input logic buf_pop,
   input logic mod_active,
   input logic carrier_en,
   input logic carrier_inv
);

   AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      buf_pop |-> buf_valid); // R2

   AST_LAUNCH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mod_active && buf_pop) |=> mod_active); // R2

   AST_NO_POP_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (stop || fault) |-> !buf_pop); // R10

   AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop || fault) |=> !mod_active); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_active |-> (!carrier_en && !carrier_inv)); // R7

   AST_PSK_GATE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_active && cfg_psk) |-> carrier_en); // R6

   AST_ASK_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_psk |-> !carrier_inv); // R5

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_active && !tick_us && !stop && !fault) |=> mod_active); // R11

   AST_NO_POP_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_active && !tick_us) |-> !buf_pop); // R8

endmodule

bind lf_halfbit_mod lfm_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_us     (tick_us),
   .cfg_psk     (cfg_psk),
   .start       (start),
   .stop        (stop),
   .fault       (fault),
   .buf_valid   (buf_valid),
   .buf_pop     (buf_pop),
   .mod_active  (mod_active),
   .carrier_en  (carrier_en),
   .carrier_inv (carrier_inv)
);

// File: tb/lf_halfbit_mod_tb.sv
`timescale 1ns/1ps
module lf_halfbit_mod_tb;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       tick_us = 1'b0;
   logic [1:0] cfg_rate = 2'd0;
   logic       cfg_psk = 1'b0;
   logic       start = 1'b0;
   logic       stop = 1'b0;
   logic       fault = 1'b0;
   logic       buf_valid = 1'b0;
   logic [1:0] buf_pair = 2'b00;
   logic       buf_pop;
   logic       mod_active;
   logic       carrier_en;
   logic       carrier_inv;

   lf_halfbit_mod u_dut (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cfg_rate(cfg_rate),
      .cfg_psk(cfg_psk), .start(start), .stop(stop), .fault(fault),
      .buf_valid(buf_valid), .buf_pair(buf_pair), .buf_pop(buf_pop),
      .mod_active(mod_active), .carrier_en(carrier_en), .carrier_inv(carrier_inv)
   );

   int n_run = 0;
   int n_fail = 0;
   int tick_div = 1;
   int cyc_n = 0;
   int wd = 0;
   int tbl [4] = '{512, 256, 160, 128};
   logic [1:0] q [$];

   // reference model state
   bit         m_act = 0;
   bit         m_half = 0;
   logic [1:0] m_pair = 2'b00;
   int         m_cnt = 0;
   bit         m_inv = 0;
   bit         m_prev = 0;

   // run metrics
   int act_cnt, en_cnt, inv_cnt, tick_act;

   function automatic bit e_done();
      return m_act && tick_us && (m_cnt >= tbl[cfg_rate] - 1);
   endfunction

   function automatic bit e_pop();
      if (stop || fault) return 1'b0;
      if (!m_act) return start && buf_valid;
      return e_done() && m_half && buf_valid;
   endfunction

   function automatic bit e_cur();
      return m_half ? m_pair[1] : m_pair[0];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_half = 0; m_cnt = 0; m_inv = 0; m_prev = 0;
      end else begin
         automatic bit done = e_done();
         automatic bit pop  = e_pop();
         automatic bit was  = m_act;
         automatic bit nb;
         if (stop || fault) begin
            m_act = 0;
         end else if (!m_act) begin
            if (start && buf_valid) begin
               m_act = 1; m_half = 0; m_pair = buf_pair; m_cnt = 0;
               m_inv = 0; m_prev = buf_pair[0];
            end
         end else if (done) begin
            m_cnt = 0;
            if (!m_half) m_half = 1;
            else if (buf_valid) begin m_pair = buf_pair; m_half = 0; end
            else m_act = 0;
         end else if (tick_us) begin
            m_cnt++;
         end
         if (was && m_act) begin
            nb = e_cur();
            if (nb != m_prev) m_inv = ~m_inv;
            m_prev = nb;
         end
         if (pop && q.size() > 0) void'(q.pop_front());
      end
   end

   task automatic check(string req, string nm, logic got, logic exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: got %0b expected %0b", req, nm, cyc_n, got, exp);
      end
   endtask

   task automatic check_int(string req, string nm, int got, int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, nm, got, exp);
      end
   endtask

   task automatic refresh();
      buf_valid = q.size() > 0;
      buf_pair  = buf_valid ? q[0] : 2'b00;
   endtask

   task automatic cyc();
      @(negedge clk);
      cyc_n++;
      refresh();
      tick_us = (cyc_n % tick_div) == 0;
      #1;
      if (rst_n) begin
         check("R2/R8", "buf_pop", buf_pop, e_pop());
         check("R7", "mod_active", mod_active, m_act);
         check("R5/R6", "carrier_en", carrier_en, m_act && (cfg_psk || e_cur()));
         check("R6", "carrier_inv", carrier_inv, m_act && cfg_psk && m_inv);
      end
      act_cnt  += int'(mod_active);
      en_cnt   += int'(carrier_en);
      inv_cnt  += int'(carrier_inv);
      tick_act += int'(mod_active && tick_us);
   endtask

   task automatic clear_metrics();
      act_cnt = 0; en_cnt = 0; inv_cnt = 0; tick_act = 0;
   endtask

   task automatic launch();
      refresh();
      clear_metrics();
      start = 1'b1;
      cyc();
      start = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 20000 && mod_active; i++) cyc();
   endtask

   task automatic push_f6();
      q.push_back(2'b10); q.push_back(2'b01); q.push_back(2'b11); q.push_back(2'b11);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_fail++;
         $display("FAIL watchdog: cycles %0d expected below 150000", wd);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      rst_n = 1'b0;
      for (int i = 0; i < 4; i++) cyc();
      check("R1", "mod_active in reset", mod_active, 1'b0);
      check("R1", "carrier_en in reset", carrier_en, 1'b0);
      check("R1", "carrier_inv in reset", carrier_inv, 1'b0);
      check("R1", "buf_pop in reset", buf_pop, 1'b0);
      rst_n = 1'b1;
      cyc();
      check("R1", "mod_active after reset", mod_active, 1'b0);

      // R2: start on empty buffer is ignored
      start = 1'b1; cyc(); start = 1'b0; cyc();
      check("R2", "start on empty buffer", mod_active, 1'b0);

      // ASK, code 0, pattern 0F6h: R3 R5 R7 R8 R9
      cfg_psk = 1'b0; cfg_rate = 2'd0; tick_div = 1;
      push_f6();
      launch();
      drain();
      check_int("R3/R8", "ASK code0 active cycles", act_cnt, 8 * 512);
      check_int("R5", "ASK carrier-on cycles", en_cnt, 6 * 512);
      check_int("R5", "ASK inverted cycles", inv_cnt, 0);
      check("R9", "idle after empty buffer", mod_active, 1'b0);

      // PSK, code 3, pattern 0F6h: R6 R3
      cfg_psk = 1'b1; cfg_rate = 2'd3;
      push_f6();
      launch();
      drain();
      check_int("R3", "PSK code3 active cycles", act_cnt, 8 * 128);
      check_int("R6", "PSK carrier-on cycles", en_cnt, 8 * 128);
      check_int("R6", "PSK inverted cycles", inv_cnt, 6 * 128);

      // R11: code 1 with tick every third cycle
      cfg_psk = 1'b0; cfg_rate = 2'd1; tick_div = 3;
      q.push_back(2'b01);
      launch();
      drain();
      check_int("R11", "ticks consumed code1", tick_act, 2 * 256);
      tick_div = 1;

      // R3: code 2
      cfg_psk = 1'b1; cfg_rate = 2'd2;
      q.push_back(2'b10);
      launch();
      drain();
      check_int("R3", "code2 active cycles", act_cnt, 2 * 160);
      check_int("R6", "code2 inverted cycles", inv_cnt, 160);

      // R4: lower half first
      cfg_psk = 1'b0; cfg_rate = 2'd3;
      q.push_back(2'b01);
      launch();
      for (int i = 0; i < 63; i++) cyc();
      check("R4", "lower half shown first", carrier_en, 1'b1);
      for (int i = 0; i < 128; i++) cyc();
      check("R4", "upper half shown second", carrier_en, 1'b0);
      drain();

      // R10: stop mid transmission
      cfg_rate = 2'd0;
      push_f6();
      launch();
      for (int i = 0; i < 100; i++) cyc();
      stop = 1'b1; cyc(); stop = 1'b0;
      check("R10", "stop ends transmission", mod_active, 1'b0);
      check("R10", "gate off after stop", carrier_en, 1'b0);
      start = 1'b1; stop = 1'b1; cyc(); start = 1'b0; stop = 1'b0;
      check("R10", "start ignored under stop", mod_active, 1'b0);

      // R10: fault in PSK
      cfg_psk = 1'b1; cfg_rate = 2'd3;
      launch();
      for (int i = 0; i < 140; i++) cyc();
      fault = 1'b1; cyc(); fault = 1'b0;
      check("R10", "fault ends transmission", mod_active, 1'b0);
      check("R10", "inversion off after fault", carrier_inv, 1'b0);
      q.delete();
      for (int i = 0; i < 4; i++) cyc();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule